// File: doc/BRIEF.md
# Data-Dependent Early-Exit Vector Sequencer

This block applies one scalar test to a vector of up to `2**VL_W-1` elements, one element at a time. A start pulse latches the requested length, a stop mode and the operand tags. For each element the block reads one word through a synchronous read port and compares it with a signed immediate. In load mode it instead reads a byte at a strided address and compares that byte with zero. The result of the compare is a three-bit condition field. An equality test on that field, with its sense chosen by a mode bit, decides whether the element fails.

On the first failing element the block stops. It shortens the vector length so that the failing element is either kept or dropped, and the result may be zero. Each condition field is written to the destination only once its element has been cleared by the sequential test. No field past the final length is ever written. If no element fails, the requested length is kept.

The source and destination each carry a vector/scalar tag. A vector-tagged operand advances by one per element. A scalar-tagged operand stays on its base. This covers scalar-scalar, scalar-vector and vector-vector use.

Top module: `vff_seq`

## Requirements
- R1: Elements are processed in order from index 0. Each element takes two cycles: `rd_en_o` is high for one cycle, and `rd_data_i` is consumed in the following cycle. Each element up to and including the stopping one is read exactly once.
- R2: The condition field is a signed comparison of operand A with operand B: `wr_cf_o[2]` = A<B, `wr_cf_o[1]` = A>B, `wr_cf_o[0]` = A==B. In compare mode (`load_mode_i`=0), A is `rd_data_i` and B is `imm_i`.
- R3: In compare mode the read address for element i is `src_base_i + i` when `src_vec_i`=1, and `src_base_i` for every element when `src_vec_i`=0.
- R4: The write index for element i is `dst_base_i + i` (modulo 2^IDX_W) when `dst_vec_i`=1, and `dst_base_i` when `dst_vec_i`=0.
- R5: An element fails when `wr_cf_o[0]` equals 1 while `fail_on_true_i`=1, or when it equals 0 while `fail_on_true_i`=0.
- R6: When element i fails, `vl_o` becomes i+1 with `keep_fail_i`=1 (the element is written), and i with `keep_fail_i`=0 (the element is not written).
- R7: A truncated length of 0 is a normal completion: `done_o` pulses with `vl_o`=0 and no write is issued.
- R8: In load mode the read address of element i is `src_base_i + imm_i*i` with `imm_i` signed, regardless of `src_vec_i`. Operand A is the zero-extended low byte of `rd_data_i`, and operand B is 0.
- R9: Writes appear in element order, one cycle after the element's compare cycle. The number of writes in a run equals the final `vl_o`.
- R10: If no element fails, `vl_o` equals the requested length. `done_o` is a one-cycle pulse that coincides with the last element's write, one cycle after its compare cycle.
- R11: `start_i` has no effect while `busy_o` is high.
- R12: `vl_o` is registered. It changes only in the cycle `done_o` is high and otherwise holds its value, including during a following run.
- R13: A requested length of 0 completes with `done_o` in the cycle after the start, with `vl_o`=0, no reads and no writes.
- R14: While reset is asserted and right after it, `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are 0 and `vl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (taken only when idle) |
| vl_i | input | VL_W | Requested vector length |
| keep_fail_i | input | 1 | 1: keep the failing element (inclusive), 0: drop it |
| fail_on_true_i | input | 1 | 1: fail on equality, 0: fail on inequality |
| load_mode_i | input | 1 | 1: strided byte load tested against zero |
| src_vec_i | input | 1 | Source is vector-tagged |
| dst_vec_i | input | 1 | Destination is vector-tagged |
| imm_i | input | DATA_W | Signed immediate (compare operand or load stride) |
| src_base_i | input | ADDR_W | Source register index or load base address |
| dst_base_i | input | IDX_W | First condition-field index |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid the cycle after `rd_en_o` |
| wr_en_o | output | 1 | Condition-field commit strobe |
| wr_idx_o | output | IDX_W | Condition-field index |
| wr_cf_o | output | 3 | Condition field {lt, gt, eq} |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| vl_o | output | VL_W | Final (possibly truncated) vector length |

## Verification
If the start is taken on edge E0 and n elements are processed, `done_o` rises after edge E0+2n. A run with a zero length completes after edge E0 itself. The bench drives on falling edges and counts falling edges from the start until `done_o`, then requires exactly 2n+1, or 1 for a zero length. On the falling edge after that it requires `done_o` to be low again and `vl_o` unchanged. Reads and writes are logged on every falling edge and compared, in order, against the addresses, indices and fields derived from the requirements. This way a write that comes early, late, extra or missing is caught, and not only a wrong final length.

// File: rtl/vff_pkg.sv
package vff_pkg;
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cf_t;

  localparam int unsigned CF_W = $bits(cf_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_EV   = 2'd2
  } st_e;
endpackage

// File: rtl/vff_cmp_test.sv
module vff_cmp_test
  import vff_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              load_i,
  input  logic              fail_on_true_i,
  output cf_t               cf_o,
  output logic              fail_o
);
  logic signed [DATA_W-1:0] op_a;
  logic signed [DATA_W-1:0] op_b;

  // load mode: zero-extended byte against zero
  always_comb begin
    op_a = load_i ? DATA_W'(data_i[BYTE_W-1:0]) : data_i;
    op_b = load_i ? '0 : imm_i;
  end

  assign cf_o.lt = op_a < op_b;
  assign cf_o.gt = op_a > op_b;
  assign cf_o.eq = op_a == op_b;
  assign fail_o  = fail_on_true_i ? cf_o.eq : ~cf_o.eq;
endmodule

// File: rtl/vff_addr_gen.sv
module vff_addr_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [IDX_W-1:0]  dst_base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              load_i,
  input  logic              src_vec_i,
  input  logic              dst_vec_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [IDX_W-1:0]  dst_idx_o
);
  logic [ADDR_W-1:0] src_q;
  logic [IDX_W-1:0]  dst_q;
  logic [ADDR_W-1:0] stride;

  // accumulated stride replaces imm*i multiply
  assign stride = load_i ? ADDR_W'($signed(imm_i)) : ADDR_W'(src_vec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (init_i) begin
      src_q <= src_base_i;
      dst_q <= dst_base_i;
    end else if (step_i) begin
      src_q <= src_q + stride;
      dst_q <= dst_q + IDX_W'(dst_vec_i);
    end
  end

  assign src_addr_o = src_q;
  assign dst_idx_o  = dst_q;
endmodule

// File: rtl/vff_seq.sv
module vff_seq
  import vff_pkg::*;
#(
  parameter int unsigned VL_W   = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              keep_fail_i,
  input  logic              fail_on_true_i,
  input  logic              load_mode_i,
  input  logic              src_vec_i,
  input  logic              dst_vec_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [IDX_W-1:0]  dst_base_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [CF_W-1:0]   wr_cf_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [VL_W-1:0]   vl_o
);
  localparam logic [VL_W-1:0] ONE = VL_W'(1);

  st_e               state_q;
  logic [VL_W-1:0]   idx_q;
  logic [VL_W-1:0]   vl_cap_q;
  logic [VL_W-1:0]   vl_q;
  logic              keep_q, fot_q, ld_q, sv_q, dv_q;
  logic [DATA_W-1:0] imm_q;
  logic              done_q;
  logic              wr_en_q;
  logic [IDX_W-1:0]  wr_idx_q;
  cf_t               wr_cf_q;

  logic              accept;
  logic              eval;
  logic              last;
  logic              stop;
  logic              keep;
  logic              fail;
  cf_t               cf;
  logic [IDX_W-1:0]  dst_idx;
  logic [VL_W-1:0]   vl_trunc;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign eval     = (state_q == ST_EV);
  assign last     = (idx_q == vl_cap_q - ONE);
  assign stop     = fail || last;
  assign keep     = !(fail && !keep_q);
  assign vl_trunc = !fail ? vl_cap_q : (keep_q ? idx_q + ONE : idx_q);

  vff_addr_gen #(
    .ADDR_W(ADDR_W),
    .IMM_W (DATA_W),
    .IDX_W (IDX_W)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (accept),
    .step_i    (eval && !stop),
    .src_base_i(src_base_i),
    .dst_base_i(dst_base_i),
    .imm_i     (imm_q),
    .load_i    (ld_q),
    .src_vec_i (sv_q),
    .dst_vec_i (dv_q),
    .src_addr_o(rd_addr_o),
    .dst_idx_o (dst_idx)
  );

  vff_cmp_test #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) u_cmp (
    .data_i        (rd_data_i),
    .imm_i         (imm_q),
    .load_i        (ld_q),
    .fail_on_true_i(fot_q),
    .cf_o          (cf),
    .fail_o        (fail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      vl_cap_q <= '0;
      vl_q     <= '0;
      keep_q   <= 1'b0;
      fot_q    <= 1'b0;
      ld_q     <= 1'b0;
      sv_q     <= 1'b0;
      dv_q     <= 1'b0;
      imm_q    <= '0;
      done_q   <= 1'b0;
      wr_en_q  <= 1'b0;
      wr_idx_q <= '0;
      wr_cf_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      wr_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vl_cap_q <= vl_i;
            keep_q   <= keep_fail_i;
            fot_q    <= fail_on_true_i;
            ld_q     <= load_mode_i;
            sv_q     <= src_vec_i;
            dv_q     <= dst_vec_i;
            imm_q    <= imm_i;
            idx_q    <= '0;
            if (vl_i == '0) begin
              done_q <= 1'b1;
              vl_q   <= '0;
            end else begin
              state_q <= ST_RD;
            end
          end
        end
        ST_RD: state_q <= ST_EV;
        ST_EV: begin
          // commit only elements inside the truncated length
          wr_en_q  <= keep;
          wr_idx_q <= dst_idx;
          wr_cf_q  <= cf;
          if (stop) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            vl_q    <= vl_trunc;
          end else begin
            idx_q   <= idx_q + ONE;
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o  = (state_q == ST_RD);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign vl_o     = vl_q;
  assign wr_en_o  = wr_en_q;
  assign wr_idx_o = wr_idx_q;
  assign wr_cf_o  = wr_cf_q;
endmodule

// File: rtl/vff_seq_chk.sv
module vff_seq_chk #(
  parameter int unsigned VL_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [VL_W-1:0] vl_i,
  input logic            rd_en_o,
  input logic            wr_en_o,
  input logic            busy_o,
  input logic            done_o,
  input logic [VL_W-1:0] vl_o
);
  logic [VL_W-1:0] cap_q;
  logic [VL_W:0]   wcnt_q;
  logic            take;

  assign take = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      wcnt_q <= '0;
    end else if (take) begin
      cap_q  <= vl_i;
      wcnt_q <= '0;
    end else if (wr_en_o) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  a_r1_read_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> busy_o);

  a_r12_vl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(vl_o));

  a_r13_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && vl_i == '0) |=> (done_o && vl_o == '0 && !busy_o));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  a_r6_vl_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (vl_o <= cap_q));

  a_r9_wr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wcnt_q < {1'b0, cap_q}));

  a_r9_wr_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({1'b0, vl_o} == wcnt_q + (VL_W+1)'(wr_en_o)));
endmodule

bind vff_seq vff_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .vl_i   (vl_i),
  .rd_en_o(rd_en_o),
  .wr_en_o(wr_en_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .vl_o   (vl_o)
);

// File: tb/vff_seq_tb.sv
`timescale 1ns/1ps
module vff_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  vl_i = '0;
  logic        keep_i = 1'b0, fot_i = 1'b0, ld_i = 1'b0, sv_i = 1'b0, dv_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic [15:0] base_i = '0;
  logic [5:0]  dbase_i = '0;
  logic        rd_en_o;
  logic [15:0] rd_addr_o;
  logic [15:0] rd_data = '0;
  logic        wr_en_o;
  logic [5:0]  wr_idx_o;
  logic [2:0]  wr_cf_o;
  logic        busy_o, done_o;
  logic [3:0]  vl_o;

  always #2.5 clk = ~clk;

  vff_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vl_i(vl_i),
    .keep_fail_i(keep_i), .fail_on_true_i(fot_i), .load_mode_i(ld_i),
    .src_vec_i(sv_i), .dst_vec_i(dv_i), .imm_i(imm_i), .src_base_i(base_i),
    .dst_base_i(dbase_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_cf_o(wr_cf_o), .busy_o(busy_o), .done_o(done_o), .vl_o(vl_o)
  );

  typedef struct packed {
    logic [3:0]  vl;
    logic        keep, fot, ld, sv, dv;
    logic [15:0] imm;
    logic [15:0] base;
    logic [5:0]  dbase;
    logic [3:0]  xvl;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t ROWS [NROWS] = '{
    '{4'd6,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5,     16'd17,  6'd8,  4'd4},
    '{4'd6,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5,     16'd17,  6'd8,  4'd3},
    '{4'd5,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5,     16'd0,   6'd0,  4'd5},
    '{4'd6,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5,     16'd20,  6'd4,  4'd0},
    '{4'd6,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5,     16'd20,  6'd4,  4'd1},
    '{4'd4,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd5,     16'd20,  6'd10, 4'd2},
    '{4'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'd5,     16'd20,  6'd12, 4'd5},
    '{4'd3,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'd5,     16'd0,   6'd30, 4'd3},
    '{4'd6,  1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'd4,     16'd32,  6'd0,  4'd3},
    '{4'd6,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd4,     16'd32,  6'd0,  4'd2},
    '{4'd6,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFC,  16'd48,  6'd16, 4'd3},
    '{4'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5,     16'd20,  6'd0,  4'd0},
    '{4'd4,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'd1,     16'd40,  6'd62, 4'd2},
    '{4'd15, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd5,     16'd100, 6'd60, 4'd15}
  };

  logic [15:0] mem [256];
  always @(posedge clk) if (rd_en_o) rd_data <= mem[rd_addr_o[7:0]];

  int tests = 0, fails = 0;
  logic [15:0] rd_log [32];
  logic [5:0]  wi_log [32];
  logic [2:0]  wc_log [32];
  int rd_n = 0, wr_n = 0;

  always @(negedge clk) begin
    if (rd_en_o && rd_n < 32) begin rd_log[rd_n] = rd_addr_o; rd_n = rd_n + 1; end
    if (wr_en_o && wr_n < 32) begin wi_log[wr_n] = wr_idx_o; wc_log[wr_n] = wr_cf_o; wr_n = wr_n + 1; end
  end

  logic [15:0] exp_ra [32];
  logic [5:0]  exp_wi [32];
  logic [2:0]  exp_wc [32];
  int exp_rd, exp_n;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model(input row_t rw);
    logic [15:0] a, v;
    int sa, sb;
    bit eq, f;
    exp_rd = 0; exp_n = 0;
    for (int i = 0; i < int'(rw.vl); i++) begin
      a = rw.ld ? rw.base + 16'($signed(rw.imm) * i) : rw.base + (rw.sv ? 16'(i) : 16'd0);
      exp_ra[exp_rd] = a; exp_rd++;
      v  = mem[a[7:0]];
      sa = rw.ld ? int'(v[7:0]) : int'($signed(v));
      sb = rw.ld ? 0 : int'($signed(rw.imm));
      eq = (sa == sb);
      f  = rw.fot ? eq : !eq;
      if (!(f && !rw.keep)) begin
        exp_wi[exp_n] = rw.dbase + (rw.dv ? 6'(i) : 6'd0);
        exp_wc[exp_n] = {sa < sb, sa > sb, eq};
        exp_n++;
      end
      if (f) break;
    end
  endtask

  task automatic run_row(input row_t rw, input bit poke);
    int k, exp_k;
    logic [3:0] prev;
    model(rw);
    exp_k = (rw.vl == 0) ? 1 : 2 * exp_rd + 1;
    prev = vl_o;
    @(negedge clk);
    vl_i = rw.vl; keep_i = rw.keep; fot_i = rw.fot; ld_i = rw.ld;
    sv_i = rw.sv; dv_i = rw.dv; imm_i = rw.imm; base_i = rw.base; dbase_i = rw.dbase;
    rd_n = 0; wr_n = 0;
    start_i = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start_i = 1'b0;
      if (poke && k == 3) begin
        // R11: a second start mid-run must be ignored
        vl_i = 4'd1; base_i = 16'd20; keep_i = 1'b0; start_i = 1'b1;
      end
      if (k == 1 && rw.vl != 0)
        chk(vl_o == prev, "R12 vl_o held during run", vl_o, prev);
    end while (!done_o && k < 80);
    start_i = 1'b0;
    chk(k == exp_k, "R1 R10 R13 done cycle", k, exp_k);
    chk(vl_o == rw.xvl, "R5 R6 R7 R10 final vl", vl_o, rw.xvl);
    @(negedge clk);
    chk(!done_o, "R10 done single pulse", done_o, 0);
    chk(vl_o == rw.xvl, "R12 vl_o stable after done", vl_o, rw.xvl);
    chk(rd_n == exp_rd, "R1 read count", rd_n, exp_rd);
    for (int j = 0; j < rd_n && j < exp_rd; j++)
      chk(rd_log[j] == exp_ra[j], "R3 R8 read address", rd_log[j], exp_ra[j]);
    chk(wr_n == exp_n, "R9 write count", wr_n, exp_n);
    chk(wr_n == int'(rw.xvl), "R9 writes equal vl", wr_n, rw.xvl);
    for (int j = 0; j < wr_n && j < exp_n; j++) begin
      chk(wi_log[j] == exp_wi[j], "R4 write index", wi_log[j], exp_wi[j]);
      chk(wc_log[j] == exp_wc[j], "R2 condition field", wc_log[j], exp_wc[j]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 16'h0100 + 16'(a);
    mem[20] = 16'd5;
    mem[21] = 16'hFFF0;
    mem[40] = 16'h0300;
    repeat (3) @(negedge clk);
    // R14 reset state
    chk(!busy_o && !done_o && !rd_en_o && !wr_en_o && vl_o == 0, "R14 in reset",
        {busy_o, done_o, rd_en_o, wr_en_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && vl_o == 0, "R14 after reset", {busy_o, done_o}, 0);

    for (int r = 0; r < NROWS; r++) run_row(ROWS[r], 1'b0);

    // R11: long run with an ignored start in the middle
    run_row(ROWS[13], 1'b1);
    chk(vl_o == 4'd15, "R11 start while busy ignored", vl_o, 15);

    // R12: idle cycles leave vl_o untouched
    repeat (5) @(negedge clk);
    chk(vl_o == 4'd15, "R12 vl_o hold while idle", vl_o, 15);

    // R13: zero length gives no reads or writes and immediate done
    run_row(ROWS[11], 1'b0);
    chk(rd_n == 0 && wr_n == 0, "R13 zero length no traffic", rd_n + wr_n, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule